// File: doc/BRIEF.md
# Full-Duplex Asynchronous Serial Channel

This block is a single full-duplex asynchronous serial channel. A character accepted on the transmit stream waits in a four-entry transmit buffer. The transmitter then serializes it as a frame: one low start bit, then the data bits least significant first, then an optional address/data marker bit, then a high stop period. The receiver deserializes incoming frames into a four-entry receive buffer. The host takes characters from that buffer over a second stream. Each direction has its own rate-enable input. A per-direction select treats that enable either as one pulse per bit or as sixteen pulses per bit. In the sixteen-pulse case the receiver samples each bit in its middle.

A two-bit routing select chooses one of four line paths: normal operation, automatic echo, local loopback or remote loopback. A multidrop option lengthens every frame by one marker bit. A marker of 1 flags the character as an address and a marker of 0 flags it as data.

Both data interfaces use valid/ready handshakes. A transfer happens on a clock edge where both valid and ready are high. On the transmit side, `tx_ready` is low while four characters are held. The host must hold `tx_valid` and its data stable until a transfer occurs. On the receive side, `rx_valid` stays high with stable data until the host raises `rx_ready`. The receiver cannot be held back by the host: a character that completes while the buffer is full is lost, and this is flagged. The configuration and status pins are plain levels.

Top module: `serial_channel`

## Requirements
- R1: After reset, `txd` is 1, `rx_valid` is 0, `tx_ready` is 1, `tx_empty` is 1, `rx_full` is 0 and `overrun` is 0, and this holds even when reset is asserted in the middle of a frame.
- R2: A transmitted frame consists of a 0 start bit, the data bits least significant first, and then a stop period at 1. Each bit lasts one rate enable when `tx_x16`=0 and sixteen rate enables when `tx_x16`=1.
- R3: The stop period, set by `stop_frac`=S, lasts 16+S enables when `tx_x16`=1. When `tx_x16`=0 it lasts 1 enable for S=0 and 2 enables otherwise.
- R4: The transmit buffer holds four characters, and `tx_ready` is 0 while it is full. `tx_empty` rises only once the buffer is empty and the final stop period has ended.
- R5: With `rx_x16`=1, a low level seen on an enable begins a start bit. The start bit is confirmed only if the line is still low eight enables later, otherwise the receiver returns to hunting. Each later bit is sampled every sixteen enables.
- R6: The receive buffer holds four characters, and `rx_full` is 1 while it holds four. A character that completes while the buffer is full is discarded and sets `overrun`. `overrun` clears on the next transfer out of the receive stream.
- R7: A stop bit sampled low is delivered with `rx_ferr`=1. The receiver then waits for the line to return to 1 before it hunts for a new start bit.
- R8: With `multidrop`=1, a marker bit follows the data bits (transmitted from `tx_addr`, received on `rx_addr`, where 1 means address). With `multidrop`=0, `tx_addr` has no effect and `rx_addr` reads 0.
- R9: `route` encoding: 0 normal, 1 echo, 2 local loopback, 3 remote loopback. In normal mode, `txd` carries the transmitter and the receiver listens to `rxd`, so traffic on `rxd` never appears on `txd`.
- R10: In echo mode, `txd` equals `rxd` one clock later, and the receiver still delivers the incoming characters.
- R11: In local loopback, the receiver listens to the transmitter internally and `txd` stays 1.
- R12: In remote loopback, `txd` equals `rxd` one clock later, and no character reaches the receive stream.
- R13: With `rx_x16`=0, the receiver takes a low level on an enable as the start bit and samples one bit on each following enable.
- R14: The transmitter advances only on `tx_rate_en` and the receiver only on `rx_rate_en`. While `tx_rate_en` is held low, a queued character is not sent, and reception still proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_rate_en | input | 1 | Transmit rate enable |
| rx_rate_en | input | 1 | Receive rate enable |
| tx_x16 | input | 1 | 1: sixteen transmit enables per bit, 0: one |
| rx_x16 | input | 1 | 1: sixteen receive enables per bit, 0: one |
| stop_frac | input | 4 | Extra stop length in sixteenths of a bit |
| multidrop | input | 1 | Adds the address/data marker bit |
| route | input | 2 | Line routing select |
| tx_valid | input | 1 | Transmit character offered |
| tx_ready | output | 1 | Transmit buffer has room |
| tx_data | input | DATA_W | Transmit character |
| tx_addr | input | 1 | Marker bit to send (1 = address) |
| rx_valid | output | 1 | Received character available |
| rx_ready | input | 1 | Host takes the received character |
| rx_data | output | DATA_W | Received character |
| rx_addr | output | 1 | Received marker bit |
| rx_ferr | output | 1 | Character had a low stop bit |
| rx_full | output | 1 | Receive buffer holds four characters |
| overrun | output | 1 | A character was lost to a full buffer |
| tx_empty | output | 1 | Transmitter and its buffer are both empty |
| rxd | input | 1 | Serial line in |
| txd | output | 1 | Serial line out |

## Verification
The assertions take for granted that `route`, the x16 selects, `stop_frac` and `multidrop` change only while no frame is moving in either direction. They also assume that `rxd` is driven as whole frames aligned to the receive enable. The stimulus keeps to this. It reprograms the configuration only after `tx_empty` has risen and the receiver has delivered or dropped its last frame. It holds each rate enable either steadily high or steadily low, so bit lengths are an exact number of clocks. It drives `rxd` one full bit period at a time from the falling clock edge.

// File: rtl/serial_channel_pkg.sv
package serial_channel_pkg;
  typedef enum logic [1:0] {
    RT_NORMAL = 2'd0,
    RT_ECHO   = 2'd1,
    RT_LOCAL  = 2'd2,
    RT_REMOTE = 2'd3
  } route_e;

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_ADDR, TX_STOP
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_ADDR, RX_STOP, RX_WAIT_MARK
  } rx_state_e;
endpackage

// File: rtl/serial_channel_fifo.sv
module serial_channel_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R6
endmodule

// File: rtl/serial_channel_tx.sv
module serial_channel_tx
  import serial_channel_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              x16,
  input  logic [3:0]        stop_frac,
  input  logic              multidrop,
  input  logic              have,
  input  logic [DATA_W-1:0] data,
  input  logic              addr,
  output logic              take,
  output logic              line,
  output logic              idle
);
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(DATA_W - 1);

  tx_state_e         state;
  logic [4:0]        rem;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] shreg;
  logic              abit;
  logic [4:0]        bit_rel, stop_rel;

  assign bit_rel  = x16 ? 5'd15 : 5'd0;
  assign stop_rel = x16 ? (5'd15 + 5'(stop_frac)) : ((stop_frac != 4'd0) ? 5'd1 : 5'd0);
  assign idle     = (state == TX_IDLE);
  assign take     = tick && have &&
                    ((state == TX_IDLE) || ((state == TX_STOP) && (rem == '0)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= TX_IDLE;
      rem   <= '0;
      idx   <= '0;
      shreg <= '0;
      abit  <= 1'b0;
      line  <= 1'b1;
    end else if (tick) begin
      if (take) begin
        state <= TX_START;
        rem   <= bit_rel;
        shreg <= data;
        abit  <= addr;
        line  <= 1'b0;
      end else if (rem != '0 && state != TX_IDLE) begin
        rem <= rem - 1'b1;
      end else begin
        case (state)
          TX_START: begin
            state <= TX_DATA;
            idx   <= '0;
            rem   <= bit_rel;
            line  <= shreg[0];
          end
          TX_DATA: begin
            rem <= bit_rel;
            if (idx == LAST_IDX) begin
              if (multidrop) begin
                state <= TX_ADDR;
                line  <= abit;
              end else begin
                state <= TX_STOP;
                rem   <= stop_rel;
                line  <= 1'b1;
              end
            end else begin
              idx   <= idx + 1'b1;
              shreg <= shreg >> 1;
              line  <= shreg[1];
            end
          end
          TX_ADDR: begin
            state <= TX_STOP;
            rem   <= stop_rel;
            line  <= 1'b1;
          end
          TX_STOP: begin
            state <= TX_IDLE;
            line  <= 1'b1;
          end
          default: begin
            state <= TX_IDLE;
            line  <= 1'b1;
          end
        endcase
      end
    end
  end

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n) take |=> !line); // R2
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> $stable(line)); // R14
endmodule

// File: rtl/serial_channel_rx.sv
module serial_channel_rx
  import serial_channel_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              x16,
  input  logic              multidrop,
  input  logic              line,
  output logic              done,
  output logic [DATA_W-1:0] dout,
  output logic              aout,
  output logic              ferr
);
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(DATA_W - 1);

  rx_state_e     state;
  logic [3:0]    rem;
  logic [IW-1:0] idx;
  logic [3:0]    bit_rel;

  assign bit_rel = x16 ? 4'd15 : 4'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      rem   <= '0;
      idx   <= '0;
      dout  <= '0;
      aout  <= 1'b0;
      ferr  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (state)
          RX_IDLE: begin
            if (!line) begin
              idx  <= '0;
              aout <= 1'b0;
              if (x16) begin
                state <= RX_START;
                rem   <= 4'd7;
              end else begin
                state <= RX_DATA;
                rem   <= 4'd0;
              end
            end
          end
          RX_START: begin
            if (rem != '0) rem <= rem - 1'b1;
            else if (line) state <= RX_IDLE;
            else begin
              state <= RX_DATA;
              rem   <= bit_rel;
            end
          end
          RX_DATA: begin
            if (rem != '0) rem <= rem - 1'b1;
            else begin
              dout <= {line, dout[DATA_W-1:1]};
              rem  <= bit_rel;
              if (idx == LAST_IDX) state <= multidrop ? RX_ADDR : RX_STOP;
              else idx <= idx + 1'b1;
            end
          end
          RX_ADDR: begin
            if (rem != '0) rem <= rem - 1'b1;
            else begin
              aout  <= line;
              state <= RX_STOP;
              rem   <= bit_rel;
            end
          end
          RX_STOP: begin
            if (rem != '0) rem <= rem - 1'b1;
            else begin
              done  <= 1'b1;
              ferr  <= !line;
              state <= line ? RX_IDLE : RX_WAIT_MARK;
            end
          end
          RX_WAIT_MARK: begin
            if (line) state <= RX_IDLE;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
endmodule

// File: rtl/serial_channel.sv
module serial_channel
  import serial_channel_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_rate_en,
  input  logic              rx_rate_en,
  input  logic              tx_x16,
  input  logic              rx_x16,
  input  logic [3:0]        stop_frac,
  input  logic              multidrop,
  input  logic [1:0]        route,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_addr,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_addr,
  output logic              rx_ferr,
  output logic              rx_full,
  output logic              overrun,
  output logic              tx_empty,
  input  logic              rxd,
  output logic              txd
);
  localparam int TXW = DATA_W + 1;
  localparam int RXW = DATA_W + 2;

  route_e rt;
  assign rt = route_e'(route);

  logic rxd_s1, rxd_s2;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxd_s1 <= 1'b1;
      rxd_s2 <= 1'b1;
    end else begin
      rxd_s1 <= rxd;
      rxd_s2 <= rxd_s1;
    end
  end

  // transmit side
  logic           txf_full, txf_empty, tx_take, tx_line, tx_idle;
  logic [TXW-1:0] txf_q;

  assign tx_ready = !txf_full;

  serial_channel_fifo #(.W(TXW), .DEPTH(DEPTH)) u_txf (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (tx_valid && !txf_full),
    .wdata ({tx_addr, tx_data}),
    .pop   (tx_take),
    .rdata (txf_q),
    .full  (txf_full),
    .empty (txf_empty)
  );

  serial_channel_tx #(.DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tx_rate_en),
    .x16       (tx_x16),
    .stop_frac (stop_frac),
    .multidrop (multidrop),
    .have      (!txf_empty),
    .data      (txf_q[DATA_W-1:0]),
    .addr      (txf_q[DATA_W]),
    .take      (tx_take),
    .line      (tx_line),
    .idle      (tx_idle)
  );

  assign tx_empty = txf_empty && tx_idle;

  // line routing
  logic rx_line;
  always_comb begin
    case (rt)
      RT_LOCAL:  rx_line = tx_line;
      RT_REMOTE: rx_line = 1'b1;
      default:   rx_line = rxd_s2;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) txd <= 1'b1;
    else begin
      case (rt)
        RT_ECHO, RT_REMOTE: txd <= rxd;
        RT_LOCAL:           txd <= 1'b1;
        default:            txd <= tx_line;
      endcase
    end
  end

  // receive side
  logic              rx_done, rx_a, rx_fe, rxf_empty, rx_accept, rx_pop;
  logic [DATA_W-1:0] rx_d;
  logic [RXW-1:0]    rxf_q;

  serial_channel_rx #(.DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (rx_rate_en),
    .x16       (rx_x16),
    .multidrop (multidrop),
    .line      (rx_line),
    .done      (rx_done),
    .dout      (rx_d),
    .aout      (rx_a),
    .ferr      (rx_fe)
  );

  assign rx_accept = rx_done && (rt != RT_REMOTE);
  assign rx_valid  = !rxf_empty;
  assign rx_pop    = rx_valid && rx_ready;

  serial_channel_fifo #(.W(RXW), .DEPTH(DEPTH)) u_rxf (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_accept && !rx_full),
    .wdata ({rx_fe, rx_a, rx_d}),
    .pop   (rx_pop),
    .rdata (rxf_q),
    .full  (rx_full),
    .empty (rxf_empty)
  );

  assign rx_data = rxf_q[DATA_W-1:0];
  assign rx_addr = rxf_q[DATA_W];
  assign rx_ferr = rxf_q[DATA_W+1];

  always_ff @(posedge clk) begin
    if (!rst_n) overrun <= 1'b0;
    else if (rx_accept && rx_full) overrun <= 1'b1;
    else if (rx_pop) overrun <= 1'b0;
  end

  AST_LOCAL_MARK: assert property (@(posedge clk) disable iff (!rst_n) (rt == RT_LOCAL) |=> txd); // R11
  AST_ECHO_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) (rt == RT_ECHO) |=> (txd == $past(rxd))); // R10
  AST_REMOTE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n) (rt == RT_REMOTE && !rx_valid) |=> !rx_valid); // R12
  AST_OVR_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n) $rose(overrun) |-> $past(rx_full)); // R6
  AST_EMPTY_MARK: assert property (@(posedge clk) disable iff (!rst_n) (tx_empty && rt == RT_NORMAL) |=> txd); // R4
endmodule

// File: tb/serial_channel_tb.sv
module serial_channel_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_rate_en = 1'b1, rx_rate_en = 1'b1;
  logic       tx_x16 = 1'b1, rx_x16 = 1'b1;
  logic [3:0] stop_frac = 4'd0;
  logic       multidrop = 1'b0;
  logic [1:0] route = 2'd0;
  logic       tx_valid = 1'b0, tx_addr = 1'b0, rx_ready = 1'b0, rxd = 1'b1;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready, rx_valid, rx_addr, rx_ferr, rx_full, overrun, tx_empty, txd;
  logic [7:0] rx_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  serial_channel u_dut (
    .clk(clk), .rst_n(rst_n), .tx_rate_en(tx_rate_en), .rx_rate_en(rx_rate_en),
    .tx_x16(tx_x16), .rx_x16(rx_x16), .stop_frac(stop_frac), .multidrop(multidrop),
    .route(route), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_addr(tx_addr), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_addr(rx_addr), .rx_ferr(rx_ferr), .rx_full(rx_full), .overrun(overrun),
    .tx_empty(tx_empty), .rxd(rxd), .txd(txd)
  );

  // {x16, multidrop, stop_frac, addr, data}
  localparam logic [14:0] VEC [8] = '{
    {1'b1, 1'b0, 4'd0,  1'b0, 8'h55},
    {1'b1, 1'b0, 4'd8,  1'b0, 8'h0F},
    {1'b1, 1'b1, 4'd15, 1'b1, 8'hA3},
    {1'b1, 1'b1, 4'd4,  1'b0, 8'h3C},
    {1'b0, 1'b0, 4'd0,  1'b0, 8'h81},
    {1'b0, 1'b0, 4'd3,  1'b0, 8'hFE},
    {1'b0, 1'b1, 4'd0,  1'b1, 8'h00},
    {1'b1, 1'b0, 4'd1,  1'b1, 8'hC6}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_tx(input logic [7:0] d, input logic a);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = d; tx_addr = a;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_tx_empty();
    for (int k = 0; k < 2000 && !tx_empty; k++) @(negedge clk);
  endtask

  // wait for a received character, compare it, take it
  task automatic get_rx(input logic [7:0] ed, input logic ea, input logic ef,
                        input string req, input bit mark_chk, input string mreq);
    bit mark_bad = 0;
    for (int k = 0; k < 1000 && !rx_valid; k++) begin
      @(negedge clk);
      if (txd !== 1'b1) mark_bad = 1;
    end
    chk(rx_valid === 1'b1 && rx_data === ed && rx_addr === ea && rx_ferr === ef, req,
        {rx_valid, rx_ferr, rx_addr, rx_data}, {1'b1, ef, ea, ed});
    if (mark_chk) chk(!mark_bad, mreq, 0, 1);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  // drive one frame on rxd; mode 0 none, 1 txd must follow rxd, 2 txd must stay 1
  task automatic drive_bit(input logic v, input int bl, input int mode, inout bit bad);
    for (int k = 0; k < bl; k++) begin
      rxd = v;
      @(negedge clk);
      if (mode == 1 && txd !== v) bad = 1;
      if (mode == 2 && txd !== 1'b1) bad = 1;
    end
  endtask

  task automatic drive_frame(input logic [7:0] d, input bit x16, input bit md, input logic a,
                             input logic stopv, input int mode, output bit bad);
    int bl = x16 ? 16 : 1;
    bad = 0;
    drive_bit(1'b0, bl, mode, bad);
    for (int i = 0; i < 8; i++) drive_bit(d[i], bl, mode, bad);
    if (md) drive_bit(a, bl, mode, bad);
    drive_bit(stopv, bl, mode, bad);
    drive_bit(1'b1, 4, mode, bad);
  endtask

  // transmit a character in normal route and decode it from txd
  task automatic tx_capture(input bit x16, input bit md, input logic [3:0] s,
                            input logic a, input logic [7:0] d);
    int bl = x16 ? 16 : 1;
    int e = 0;
    int exp_e;
    logic [7:0] got;
    logic ga = 1'b0;
    logic st;
    push_tx(d, a);
    for (int k = 0; k < 200 && txd !== 1'b0; k++) @(negedge clk);
    repeat (bl / 2) @(negedge clk);
    e = bl / 2;
    st = txd;
    for (int i = 0; i < 8; i++) begin
      repeat (bl) @(negedge clk);
      e += bl;
      got[i] = txd;
    end
    if (md) begin
      repeat (bl) @(negedge clk);
      e += bl;
      ga = txd;
    end
    for (int k = 0; k < 500 && !tx_empty; k++) begin
      @(negedge clk);
      e++;
    end
    chk(st === 1'b0 && got === d, "R2 frame bits", {st, got}, {1'b0, d});
    if (md) chk(ga === a, "R8 marker bit", ga, a);
    exp_e = bl * (9 + (md ? 1 : 0)) + (x16 ? 16 + int'(s) : (s == 0 ? 1 : 2)) - 1;
    chk(e == exp_e && txd === 1'b1, "R3/R4 stop length and tx_empty timing", e, exp_e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txd === 1 && rx_valid === 0 && tx_ready === 1 && tx_empty === 1 && rx_full === 0 && overrun === 0,
        "R1 reset state", {txd, rx_valid, tx_ready, tx_empty, rx_full, overrun}, 6'b101100);

    // vector table: normal-route frame decode, then local loopback reception
    for (int i = 0; i < 8; i++) begin
      logic [14:0] v = VEC[i];
      tx_x16 = v[14]; rx_x16 = v[14]; multidrop = v[13]; stop_frac = v[12:9];
      route = 2'd0;
      tx_capture(v[14], v[13], v[12:9], v[8], v[7:0]);
      route = 2'd2;  // R11 local loopback
      @(negedge clk);
      push_tx(v[7:0], v[8]);
      get_rx(v[7:0], v[13] ? v[8] : 1'b0, 1'b0, "R11/R8 local loopback data", 1'b1, "R11 txd at mark");
      wait_tx_empty();
    end
    route = 2'd0; multidrop = 1'b0; stop_frac = 4'd0; tx_x16 = 1'b1; rx_x16 = 1'b1;
    repeat (4) @(negedge clk);

    // R5 glitch on start bit ignored
    rxd = 1'b0; repeat (4) @(negedge clk);
    rxd = 1'b1; repeat (40) @(negedge clk);
    chk(rx_valid === 1'b0, "R5 glitch ignored", rx_valid, 0);
    drive_frame(8'h6D, 1, 0, 0, 1, 2, bad);
    get_rx(8'h6D, 0, 0, "R5 mid-bit reception", 0, "");
    chk(!bad, "R9 normal route keeps rxd off txd", bad, 0);

    // R7 framing error and recovery
    drive_frame(8'h27, 1, 0, 0, 0, 0, bad);
    get_rx(8'h27, 0, 1, "R7 framing error flagged", 0, "");
    drive_frame(8'hB4, 1, 0, 0, 1, 0, bad);
    get_rx(8'hB4, 0, 0, "R7 recovery after break", 0, "");

    // R13 1x reception
    rx_x16 = 1'b0;
    drive_frame(8'h96, 0, 0, 0, 1, 0, bad);
    get_rx(8'h96, 0, 0, "R13 1x reception", 0, "");
    rx_x16 = 1'b1;

    // R6 receive buffer full and overrun
    for (int i = 0; i < 4; i++) drive_frame(8'h10 + 8'(i), 1, 0, 0, 1, 0, bad);
    repeat (4) @(negedge clk);
    chk(rx_full === 1'b1 && overrun === 1'b0, "R6 rx_full at four", {rx_full, overrun}, 2'b10);
    drive_frame(8'hEE, 1, 0, 0, 1, 0, bad);
    repeat (4) @(negedge clk);
    chk(overrun === 1'b1, "R6 overrun set", overrun, 1);
    get_rx(8'h10, 0, 0, "R6 first kept character", 0, "");
    chk(overrun === 1'b0 && rx_full === 1'b0, "R6 overrun cleared by pop", {overrun, rx_full}, 0);
    for (int i = 1; i < 4; i++) get_rx(8'h10 + 8'(i), 0, 0, "R6 kept order", 0, "");
    repeat (2) @(negedge clk);
    chk(rx_valid === 1'b0, "R6 fifth discarded", rx_valid, 0);

    // R10 echo
    route = 2'd1;
    drive_frame(8'h5E, 1, 0, 0, 1, 1, bad);
    chk(!bad, "R10 txd follows rxd", bad, 0);
    get_rx(8'h5E, 0, 0, "R10 echo still receives", 0, "");

    // R12 remote loopback
    route = 2'd3;
    drive_frame(8'hA1, 1, 0, 0, 1, 1, bad);
    chk(!bad, "R12 txd follows rxd", bad, 0);
    repeat (30) @(negedge clk);
    chk(rx_valid === 1'b0, "R12 no host data", rx_valid, 0);
    route = 2'd0;
    repeat (4) @(negedge clk);

    // R14 transmitter frozen while receiver runs
    tx_rate_en = 1'b0;
    push_tx(8'h42, 1'b0);
    drive_frame(8'h5A, 1, 0, 0, 1, 2, bad);
    get_rx(8'h5A, 0, 0, "R14 receiver independent", 0, "");
    chk(!bad && tx_empty === 1'b0, "R14 transmitter held", {bad, tx_empty}, 2'b00);

    // R4 transmit buffer depth
    for (int i = 0; i < 3; i++) push_tx(8'h70 + 8'(i), 1'b0);
    chk(tx_ready === 1'b0, "R4 tx_ready low when full", tx_ready, 0);
    tx_rate_en = 1'b1;
    wait_tx_empty();
    chk(tx_empty === 1'b1 && tx_ready === 1'b1 && txd === 1'b1, "R4 drained", {tx_empty, tx_ready, txd}, 3'b111);

    // R8 marker input ignored when multidrop off (checked through loopback)
    route = 2'd2; multidrop = 1'b0;
    push_tx(8'h3A, 1'b1);
    push_tx(8'hC5, 1'b1);
    get_rx(8'h3A, 0, 0, "R8 marker ignored first", 0, "");
    get_rx(8'hC5, 0, 0, "R8 marker ignored second", 0, "");
    wait_tx_empty();
    route = 2'd0;

    // R1 reset in mid-frame
    push_tx(8'h00, 1'b0);
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(txd === 1 && tx_empty === 1 && tx_ready === 1 && rx_valid === 0, "R1 mid-frame reset",
        {txd, tx_empty, tx_ready, rx_valid}, 4'b1110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule